// File: doc/BRIEF.md
# Codec Sample-Rate Pacing Controller

This block sets the pace of a two-channel multimedia serial port that serves an audio codec and a telecom codec. It holds one control word. That word has a 7-bit sample-rate divisor for each channel, a port enable, a receive capture mode and two transmit interrupt masks. For each channel a timer counts serial-clock ticks and fires a one-cycle sample strobe once every 32 × divisor ticks. The strobe tells the surrounding logic when to take the next transmit word from that channel's FIFO.

The block also gates writes into each channel's receive FIFO. In free-running capture, every receive-valid pulse is written. In timed capture, the first valid pulse after the mode is armed is written, and after that only the channel's sample strobe writes. Two interrupt outputs signal that a transmit FIFO holds half its depth or less, each gated by its own mask. The FIFO fill levels come in as inputs. The frame shifter, the FIFO storage and the pin routing belong to neighbouring blocks.

Top module: `codec_pace_ctrl`

## Requirements
- R1: After reset the control word reads 0, no strobe, receive write or interrupt is active, and `pins_released` is 1.
- R2: The control word maps as follows: audio divisor bits 6:0, telecom divisor bits 14:8, port enable bit 16, capture mode bit 18, telecom transmit mask bit 19, audio transmit mask bit 20. All other bits read 0 and ignore writes. A divisor reads back exactly as it was written.
- R3: With the port enabled and a tick on every clock, consecutive audio strobes are 32 × audio divisor cycles apart.
- R4: With the port enabled and a tick on every clock, consecutive telecom strobes are 32 × telecom divisor cycles apart.
- R5: A divisor below its channel minimum (6 for audio, 16 for telecom) times the channel as if it were the minimum.
- R6: A new divisor has no effect on the period already under way. It applies from the next reload.
- R7: While the enable bit is 0, neither channel produces a strobe or a receive write, and `pins_released` is 1. While the enable bit is 1, `pins_released` is 0.
- R8: With capture mode 0, a channel's receive write is high in every cycle in which its receive-valid is high.
- R9: With capture mode 1, a channel's first receive-valid writes. After that, receive writes occur only in that channel's strobe cycles, whatever the state of receive-valid.
- R10: The first-valid lock of capture mode 1 clears when the port is disabled or when the mode is left. After either event, the next valid pulse writes again.
- R11: The telecom interrupt is high exactly when bit 19 is set and the telecom transmit level is at most half the FIFO depth (at most 4 for depth 8).
- R12: The audio interrupt is high exactly when bit 20 is set and the audio transmit level is at most half the FIFO depth.
- R13: The timers advance only in cycles where `sclk_tick` is high. With a tick every other cycle, the strobe spacing in clock cycles doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_tick | input | 1 | One-cycle pulse per serial-clock period |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| aud_rx_valid | input | 1 | Audio receive word valid |
| tel_rx_valid | input | 1 | Telecom receive word valid |
| aud_tx_level | input | 4 | Audio transmit FIFO fill level |
| tel_tx_level | input | 4 | Telecom transmit FIFO fill level |
| aud_tx_strobe | output | 1 | Audio sample strobe (take next transmit word) |
| tel_tx_strobe | output | 1 | Telecom sample strobe |
| aud_rx_wr | output | 1 | Write audio receive word into its FIFO |
| tel_rx_wr | output | 1 | Write telecom receive word into its FIFO |
| aud_tx_irq | output | 1 | Masked audio transmit low-level interrupt |
| tel_tx_irq | output | 1 | Masked telecom transmit low-level interrupt |
| pins_released | output | 1 | Port disabled, serial pins free for other use |

## Verification
The assertions check the following on every cycle: the disabled port stays silent, the reserved bits stay zero, the masks gate the interrupts, capture mode 0 writes on every valid, and capture mode 1 writes only on valid or strobe. A gap counter also checks that audio strobes are never closer together than the minimum period. The exact strobe spacing and the clamping of small divisors can only be seen in the bench's scenarios, which measure the intervals. The same holds for the deferred divisor change, the single write that sets the lock, and the clearing of the lock on disable and on a mode change.

// File: rtl/pace_pkg.sv
package pace_pkg;
   localparam int AUD_DIV_LSB  = 0;
   localparam int TEL_DIV_LSB  = 8;
   localparam int EN_BIT       = 16;
   localparam int MODE_BIT     = 18;
   localparam int TEL_MASK_BIT = 19;
   localparam int AUD_MASK_BIT = 20;
   localparam int NUM_CH       = 2;

   typedef enum logic {
      RX_ON_VALID = 1'b0,
      RX_ON_TIMER = 1'b1
   } rx_mode_e;
endpackage

// File: rtl/pace_ctrl_reg.sv
module pace_ctrl_reg
   import pace_pkg::*;
#(
   parameter int DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:0]      wdata,
   output logic [DIV_W-1:0] aud_div,
   output logic [DIV_W-1:0] tel_div,
   output logic             port_en,
   output rx_mode_e         rx_mode,
   output logic             aud_mask,
   output logic             tel_mask,
   output logic [31:0]      rdata
);
   initial begin
      if (DIV_W < 1 || DIV_W > TEL_DIV_LSB - AUD_DIV_LSB)
         $error("pace_ctrl_reg: DIV_W must lie in 1..8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aud_div  <= '0;
         tel_div  <= '0;
         port_en  <= 1'b0;
         rx_mode  <= RX_ON_VALID;
         aud_mask <= 1'b0;
         tel_mask <= 1'b0;
      end else if (wr_en) begin
         aud_div  <= wdata[AUD_DIV_LSB +: DIV_W];
         tel_div  <= wdata[TEL_DIV_LSB +: DIV_W];
         port_en  <= wdata[EN_BIT];
         rx_mode  <= rx_mode_e'(wdata[MODE_BIT]);
         aud_mask <= wdata[AUD_MASK_BIT];
         tel_mask <= wdata[TEL_MASK_BIT];
      end
   end

   always_comb begin
      rdata                          = '0;
      rdata[AUD_DIV_LSB +: DIV_W]    = aud_div;
      rdata[TEL_DIV_LSB +: DIV_W]    = tel_div;
      rdata[EN_BIT]                  = port_en;
      rdata[MODE_BIT]                = rx_mode;
      rdata[TEL_MASK_BIT]            = tel_mask;
      rdata[AUD_MASK_BIT]            = aud_mask;
   end
endmodule

// File: rtl/pace_timer.sv
module pace_timer #(
   parameter int DIV_W       = 7,
   parameter int MIN_DIV     = 6,
   parameter int FRAME_SHIFT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [DIV_W-1:0] div,
   output logic             strobe
);
   localparam int                CNT_W = DIV_W + FRAME_SHIFT;
   localparam logic [DIV_W-1:0]  MIN_V = DIV_W'(MIN_DIV);

   initial begin
      if (MIN_DIV < 1 || MIN_DIV >= (1 << DIV_W))
         $error("pace_timer: MIN_DIV out of range for DIV_W");
   end

   logic [DIV_W-1:0] eff_div;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             expire;

   assign eff_div    = (div < MIN_V) ? MIN_V : div;
   assign reload_val = {eff_div, {FRAME_SHIFT{1'b0}}} - CNT_W'(1);
   assign expire     = run && armed_q && tick && (cnt_q == '0);
   assign strobe     = expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!run) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!armed_q) begin
         cnt_q   <= reload_val;
         armed_q <= 1'b1;
      end else if (tick) begin
         cnt_q   <= expire ? reload_val : cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/pace_rx_gate.sv
module pace_rx_gate
   import pace_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  rx_mode_e mode,
   input  logic     valid,
   input  logic     strobe,
   output logic     wr
);
   logic locked_q;
   logic timed;

   assign timed = run && (mode == RX_ON_TIMER);

   always_comb begin
      if (!run)
         wr = 1'b0;
      else if (mode == RX_ON_VALID)
         wr = valid;
      else
         wr = locked_q ? strobe : valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked_q <= 1'b0;
      else if (!timed)
         locked_q <= 1'b0;
      else if (valid)
         locked_q <= 1'b1;
   end
endmodule

// File: rtl/codec_pace_ctrl.sv
module codec_pace_ctrl
   import pace_pkg::*;
#(
   parameter int DIV_W       = 7,
   parameter int FRAME_SHIFT = 5,
   parameter int AUD_MIN_DIV = 6,
   parameter int TEL_MIN_DIV = 16,
   parameter int FIFO_DEPTH  = 8,
   parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_tick,
   input  logic             cfg_wr_en,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic             aud_rx_valid,
   input  logic             tel_rx_valid,
   input  logic [LVL_W-1:0] aud_tx_level,
   input  logic [LVL_W-1:0] tel_tx_level,
   output logic             aud_tx_strobe,
   output logic             tel_tx_strobe,
   output logic             aud_rx_wr,
   output logic             tel_rx_wr,
   output logic             aud_tx_irq,
   output logic             tel_tx_irq,
   output logic             pins_released
);
   localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(FIFO_DEPTH / 2);

   initial begin
      if (FIFO_DEPTH < 2 || (1 << LVL_W) <= FIFO_DEPTH)
         $error("codec_pace_ctrl: FIFO_DEPTH/LVL_W mismatch");
   end

   logic [DIV_W-1:0] aud_div, tel_div;
   logic             port_en, aud_mask, tel_mask;
   rx_mode_e         rx_mode;

   pace_ctrl_reg #(.DIV_W(DIV_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .wdata    (cfg_wdata),
      .aud_div  (aud_div),
      .tel_div  (tel_div),
      .port_en  (port_en),
      .rx_mode  (rx_mode),
      .aud_mask (aud_mask),
      .tel_mask (tel_mask),
      .rdata    (cfg_rdata)
   );

   logic [NUM_CH-1:0][DIV_W-1:0] ch_div;
   logic [NUM_CH-1:0][LVL_W-1:0] ch_lvl;
   logic [NUM_CH-1:0]            ch_valid, ch_strobe, ch_wr, ch_mask, ch_irq;

   assign ch_div   = {tel_div, aud_div};
   assign ch_lvl   = {tel_tx_level, aud_tx_level};
   assign ch_valid = {tel_rx_valid, aud_rx_valid};
   assign ch_mask  = {tel_mask, aud_mask};

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int CH_MIN = (ch == 0) ? AUD_MIN_DIV : TEL_MIN_DIV;

      pace_timer #(
         .DIV_W       (DIV_W),
         .MIN_DIV     (CH_MIN),
         .FRAME_SHIFT (FRAME_SHIFT)
      ) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (port_en),
         .tick   (sclk_tick),
         .div    (ch_div[ch]),
         .strobe (ch_strobe[ch])
      );

      pace_rx_gate u_rx (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (port_en),
         .mode   (rx_mode),
         .valid  (ch_valid[ch]),
         .strobe (ch_strobe[ch]),
         .wr     (ch_wr[ch])
      );

      assign ch_irq[ch] = ch_mask[ch] && (ch_lvl[ch] <= HALF_LVL);
   end

   assign aud_tx_strobe = ch_strobe[0];
   assign tel_tx_strobe = ch_strobe[1];
   assign aud_rx_wr     = ch_wr[0];
   assign tel_rx_wr     = ch_wr[1];
   assign aud_tx_irq    = ch_irq[0];
   assign tel_tx_irq    = ch_irq[1];
   assign pins_released = !port_en;
endmodule

// File: rtl/codec_pace_ctrl_chk.sv
module codec_pace_ctrl_chk
   import pace_pkg::*;
#(
   parameter int FRAME_SHIFT = 5,
   parameter int AUD_MIN_DIV = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cfg_rdata,
   input logic        aud_rx_valid,
   input logic        aud_tx_strobe,
   input logic        tel_tx_strobe,
   input logic        aud_rx_wr,
   input logic        tel_rx_wr,
   input logic        aud_tx_irq,
   input logic        tel_tx_irq,
   input logic        pins_released
);
   localparam logic [31:0] RSV_MASK = ~(32'h7F << AUD_DIV_LSB | 32'h7F << TEL_DIV_LSB
                                       | 32'h1 << EN_BIT | 32'h1 << MODE_BIT
                                       | 32'h1 << TEL_MASK_BIT | 32'h1 << AUD_MASK_BIT);
   localparam int MIN_GAP = AUD_MIN_DIV << FRAME_SHIFT;

   logic        en, timed;
   logic [15:0] gap_q;
   logic        seen_q;

   assign en    = cfg_rdata[EN_BIT];
   assign timed = cfg_rdata[MODE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (!en) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (aud_tx_strobe) begin
         gap_q  <= 16'd1;
         seen_q <= 1'b1;
      end else if (gap_q != 16'hFFFF) begin
         gap_q  <= gap_q + 16'd1;
      end
   end

   // R7
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!aud_tx_strobe && !tel_tx_strobe && !aud_rx_wr && !tel_rx_wr));
   // R7
   pins_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pins_released != en);
   // R2
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & RSV_MASK) == 32'h0);
   // R11
   tel_irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[TEL_MASK_BIT] |-> !tel_tx_irq);
   // R12
   aud_irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[AUD_MASK_BIT] |-> !aud_tx_irq);
   // R8
   mode0_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !timed && aud_rx_valid) |-> aud_rx_wr);
   // R9
   mode1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && timed && aud_rx_wr) |-> (aud_rx_valid || aud_tx_strobe));
   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aud_tx_strobe |=> !aud_tx_strobe);
   // R5
   min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aud_tx_strobe && seen_q) |-> (gap_q >= 16'(MIN_GAP)));
endmodule

bind codec_pace_ctrl codec_pace_ctrl_chk #(
   .FRAME_SHIFT (FRAME_SHIFT),
   .AUD_MIN_DIV (AUD_MIN_DIV)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_rdata     (cfg_rdata),
   .aud_rx_valid  (aud_rx_valid),
   .aud_tx_strobe (aud_tx_strobe),
   .tel_tx_strobe (tel_tx_strobe),
   .aud_rx_wr     (aud_rx_wr),
   .tel_rx_wr     (tel_rx_wr),
   .aud_tx_irq    (aud_tx_irq),
   .tel_tx_irq    (tel_tx_irq),
   .pins_released (pins_released)
);

// File: tb/tb_codec_pace_ctrl.sv
module tb_codec_pace_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EN   = 32'h1 << 16;
   localparam logic [31:0] MODE = 32'h1 << 18;
   localparam logic [31:0] TMSK = 32'h1 << 19;
   localparam logic [31:0] AMSK = 32'h1 << 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk_tick = 1'b1;
   logic        tick_half = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        aud_rx_valid = 1'b0, tel_rx_valid = 1'b0;
   logic [3:0]  aud_tx_level = 4'd8, tel_tx_level = 4'd8;
   logic        aud_tx_strobe, tel_tx_strobe, aud_rx_wr, tel_rx_wr;
   logic        aud_tx_irq, tel_tx_irq, pins_released;

   int checks = 0;
   int errors = 0;

   codec_pace_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick),
      .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .aud_rx_valid(aud_rx_valid), .tel_rx_valid(tel_rx_valid),
      .aud_tx_level(aud_tx_level), .tel_tx_level(tel_tx_level),
      .aud_tx_strobe(aud_tx_strobe), .tel_tx_strobe(tel_tx_strobe),
      .aud_rx_wr(aud_rx_wr), .tel_rx_wr(tel_rx_wr),
      .aud_tx_irq(aud_tx_irq), .tel_tx_irq(tel_tx_irq),
      .pins_released(pins_released)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         sclk_tick = tick_half ? ~sclk_tick : 1'b1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic wait_strobe(input bit tel);
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if ((tel ? tel_tx_strobe : aud_tx_strobe) === 1'b1) return;
      end
   endtask

   task automatic measure_gap(input bit tel, output int gap);
      wait_strobe(tel);
      gap = 0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         gap++;
         if ((tel ? tel_tx_strobe : aud_tx_strobe) === 1'b1) break;
      end
   endtask

   task automatic t_reset();
      chk("R1 rdata", cfg_rdata, 32'h0);
      chk("R1 strobes", {aud_tx_strobe, tel_tx_strobe, aud_rx_wr, tel_rx_wr}, 0);
      chk("R1 irqs", {aud_tx_irq, tel_tx_irq}, 0);
      chk("R1 pins_released", pins_released, 1);
   endtask

   task automatic t_regmap();
      write_cfg(32'hFFFF_FFFF);
      chk("R2 all ones readback", cfg_rdata, 32'h001D_7F7F);
      write_cfg(32'h0000_2A05 | MODE);
      chk("R2 field readback", cfg_rdata, 32'h0004_2A05);
      write_cfg(32'h0);
      chk("R2 cleared", cfg_rdata, 32'h0);
   endtask

   task automatic t_period();
      int g;
      write_cfg(EN | (32'd16 << 8) | 32'd6);
      measure_gap(0, g); chk("R3 audio gap div 6", g, 192);
      measure_gap(1, g); chk("R4 telecom gap div 16", g, 512);
      write_cfg(EN | (32'd20 << 8) | 32'd10);
      measure_gap(0, g);
      measure_gap(0, g); chk("R3 audio gap div 10", g, 320);
      measure_gap(1, g);
      measure_gap(1, g); chk("R4 telecom gap div 20", g, 640);
   endtask

   task automatic t_clamp();
      int g;
      write_cfg(0);
      write_cfg(EN | (32'd9 << 8) | 32'd2);
      chk("R5 raw divisor readback", cfg_rdata[14:0], 15'h0902);
      measure_gap(0, g); chk("R5 audio clamp to 6", g, 192);
      measure_gap(1, g); chk("R5 telecom clamp to 16", g, 512);
   endtask

   task automatic t_reload();
      int g;
      write_cfg(0);
      write_cfg(EN | (32'd16 << 8) | 32'd6);
      wait_strobe(0);
      cfg_wr_en = 1'b1;
      cfg_wdata = EN | (32'd16 << 8) | 32'd8;
      g = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         cfg_wr_en = 1'b0;
         g++;
         if (aud_tx_strobe === 1'b1) break;
      end
      chk("R6 period in progress keeps old divisor", g, 192);
      g = 0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         g++;
         if (aud_tx_strobe === 1'b1) break;
      end
      chk("R6 next period uses new divisor", g, 256);
   endtask

   task automatic t_tick();
      int g;
      write_cfg(EN | (32'd16 << 8) | 32'd6);
      tick_half = 1'b1;
      measure_gap(0, g);
      measure_gap(0, g); chk("R13 half-rate tick doubles gap", g, 384);
      tick_half = 1'b0;
   endtask

   task automatic t_disable();
      int s = 0;
      write_cfg((32'd16 << 8) | 32'd6 | MODE);
      aud_rx_valid = 1'b1;
      tel_rx_valid = 1'b1;
      for (int i = 0; i < 700; i++) begin
         @(negedge clk);
         s += int'(aud_tx_strobe) + int'(tel_tx_strobe) + int'(aud_rx_wr) + int'(tel_rx_wr);
      end
      aud_rx_valid = 1'b0;
      tel_rx_valid = 1'b0;
      chk("R7 no strobe or write while disabled", s, 0);
      chk("R7 pins released while disabled", pins_released, 1);
      write_cfg(EN | (32'd16 << 8) | 32'd6);
      chk("R7 pins held while enabled", pins_released, 0);
   endtask

   task automatic t_mode0();
      int w = 0, tw = 0;
      write_cfg(EN | (32'd16 << 8) | 32'd6);
      @(negedge clk);
      aud_rx_valid = 1'b1;
      tel_rx_valid = 1'b1;
      for (int i = 0; i < 5; i++) begin
         #1;
         w += int'(aud_rx_wr);
         tw += int'(tel_rx_wr);
         @(negedge clk);
      end
      aud_rx_valid = 1'b0;
      tel_rx_valid = 1'b0;
      #1;
      chk("R8 audio write per valid", w, 5);
      chk("R8 telecom write per valid", tw, 5);
      chk("R8 no write without valid", aud_rx_wr, 0);
   endtask

   task automatic t_mode1();
      int mism = 0, wr = 0;
      write_cfg(0);
      write_cfg(EN | MODE | (32'd16 << 8) | 32'd6);
      aud_rx_valid = 1'b1;
      #1;
      chk("R9 first valid writes", aud_rx_wr, 1);
      @(negedge clk);
      for (int i = 0; i < 600; i++) begin
         #1;
         if (aud_rx_wr !== aud_tx_strobe) mism++;
         wr += int'(aud_rx_wr);
         @(negedge clk);
      end
      aud_rx_valid = 1'b0;
      chk("R9 writes only on strobe after lock", mism, 0);
      chk("R9 timed writes in 600 cycles", wr, 3);
   endtask

   task automatic t_relock();
      write_cfg(MODE | (32'd16 << 8) | 32'd6);
      write_cfg(EN | MODE | (32'd16 << 8) | 32'd6);
      aud_rx_valid = 1'b1;
      #1;
      chk("R10 strobe idle after re-enable", aud_tx_strobe, 0);
      chk("R10 write after disable", aud_rx_wr, 1);
      @(negedge clk);
      aud_rx_valid = 1'b0;
      wait_strobe(0);
      write_cfg(EN | (32'd16 << 8) | 32'd6);
      write_cfg(EN | MODE | (32'd16 << 8) | 32'd6);
      aud_rx_valid = 1'b1;
      #1;
      chk("R10 strobe idle at mode-change probe", aud_tx_strobe, 0);
      chk("R10 write after mode change", aud_rx_wr, 1);
      @(negedge clk);
      #1;
      chk("R10 relocked after second valid", aud_rx_wr, aud_tx_strobe);
      @(negedge clk);
      aud_rx_valid = 1'b0;
   endtask

   task automatic t_irq();
      write_cfg(TMSK);
      tel_tx_level = 4'd4; aud_tx_level = 4'd0;
      #1;
      chk("R11 telecom irq at half", tel_tx_irq, 1);
      chk("R12 audio irq masked", aud_tx_irq, 0);
      @(negedge clk);
      tel_tx_level = 4'd5;
      #1;
      chk("R11 telecom irq above half", tel_tx_irq, 0);
      write_cfg(AMSK);
      tel_tx_level = 4'd0; aud_tx_level = 4'd4;
      #1;
      chk("R12 audio irq at half", aud_tx_irq, 1);
      chk("R11 telecom irq masked", tel_tx_irq, 0);
      @(negedge clk);
      aud_tx_level = 4'd7;
      #1;
      chk("R12 audio irq above half", aud_tx_irq, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_period();
      t_clamp();
      t_reload();
      t_tick();
      t_disable();
      t_mode0();
      t_mode1();
      t_relock();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule